// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles and returns a 2N-bit product. It keeps one 2N-bit working register. A start request loads the multiplier into the low half of that register and clears the high half. On every following cycle the block looks at bit 0 of the register. When that bit is set, it adds the stored multiplicand into the high half. In the same cycle it shifts the whole register, including the adder carry, one place to the right.

Only one N-bit adder is used, and each multiplier bit takes one cycle. A client pulses start while the block is idle. It can watch busy, or wait for the one-cycle done pulse, and then read the product. The product stays readable until the next accepted start.

Top module: `seq_shift_mul`

## Requirements
- R1: When done_o is high, product_o equals mcand_i × mplier_i as captured at the accepted start, as an unsigned 2N-bit value.
- R2: A start_i seen at a clock edge while busy_o is low is accepted. After that edge busy_o is 1, the high N bits of product_o are 0 and the low N bits hold the multiplier.
- R3: In each step, if bit 0 of the working register is 1, the multiplicand is added to the high half. If bit 0 is 0, the high half is not added to.
- R4: In each step the whole register, with the adder carry placed in bit 2N-1, shifts right by one. After k steps product_o equals (mcand × (mplier mod 2^k)) × 2^(N-k) + floor(mplier / 2^k).
- R5: Exactly N steps follow an accepted start. busy_o stays high through them. busy_o falls and done_o is high for exactly one cycle after the N-th step.
- R6: With N=4, 0010 × 0011 gives 0001_0001 after step 1, 0001_1000 after step 2 and 0000_0110 at done.
- R7: The carry out of the N-bit add is never lost, so the all-ones operands give (2^N-1)^2.
- R8: A start_i while busy_o is high is ignored. The operation in flight and its result are unchanged.
- R9: While idle, product_o holds its value until the next accepted start, whatever the operand inputs do.
- R10: After reset, busy_o and done_o are 0 and product_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mcand_i | input | N | Multiplicand, captured at start |
| mplier_i | input | N | Multiplier, captured at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Working register / final product |

## Verification
The assertions assume that reset is released only between clock edges. They also assume start_i is a clean synchronous level, so an accepted start is the only event that reloads the register. The bench changes start_i and the operands only on falling edges. It sweeps every operand pair of a 4-bit instance and compares every intermediate register value with the closed form of R4. It pulses start during a run and toggles the operands while idle, so that R8 and R9 are observed at the product output.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import mul_pkg::*;

  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (state_q == MUL_RUN);
  assign load_o = start_i && !busy_o;   // start while busy is dropped
  assign step_o = busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MUL_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        state_q <= MUL_RUN;
        cnt_q   <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_q <= MUL_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] hi_i,
  input  logic [N-1:0] mcand_i,
  input  logic         en_i,
  output logic [N:0]   sum_o
);
  logic [N-1:0] addend;
  assign addend = en_i ? mcand_i : '0;
  assign sum_o  = {1'b0, hi_i} + {1'b0, addend};
endmodule

// File: rtl/mul_preg.sv
module mul_preg #(
  parameter int unsigned N = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  input  logic [N:0]     sum_i,
  output logic [N-1:0]   mcand_o,
  output logic [2*N-1:0] prod_o
);
  localparam int unsigned PW = 2 * N;

  logic [PW-1:0] prod_q;
  logic [N-1:0]  mcand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      prod_q  <= {{N{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      // carry lands in the MSB, low half drops its consumed bit
      prod_q <= {sum_i, prod_q[N-1:1]};
    end
  end

  assign prod_o  = prod_q;
  assign mcand_o = mcand_q;

  assert_mcand_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(mcand_q));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(prod_q));
  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (prod_q[PW-1:N] == '0));
endmodule

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int unsigned N = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  logic         load, step;
  logic [N-1:0] mcand_q;
  logic [N:0]   sum;

  mul_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_adder #(.N(N)) u_add (
    .hi_i   (product_o[2*N-1:N]),
    .mcand_i(mcand_q),
    .en_i   (product_o[0]),
    .sum_o  (sum)
  );

  mul_preg #(.N(N)) u_preg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .sum_i   (sum),
    .mcand_o (mcand_q),
    .prod_o  (product_o)
  );

  assert_no_add_on_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !product_o[0]) |=> (product_o[2*N-1] == 1'b0));
endmodule

// File: tb/seq_shift_mul_tb_top.sv
module seq_shift_mul_tb_top;
  localparam int NB = 4;
  localparam int PW = 2 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] a = '0, b = '0;
  logic          busy, done;
  logic [PW-1:0] prod;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  seq_shift_mul #(.N(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(a), .mplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int partial(input int x, input int y, input int k);
    partial = ((x * (y % (1 << k))) << (NB - k)) + (y >> k);
  endfunction

  task automatic run_op(input int x, input int y, input bit poke, input bit trace);
    @(negedge clk);
    a = NB'(x); b = NB'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (trace) begin
      check("R2 busy", int'(busy), 1);
      check("R2 load", int'(prod), y);
    end
    for (int k = 1; k <= NB; k++) begin
      if (poke && k == 1) begin
        a = ~a; b = ~b; start = 1'b1;   // R8: ignored request
      end
      @(negedge clk);
      start = 1'b0;
      if (trace) check("R4 step value", int'(prod), partial(x, y, k));
      if (k < NB) check("R5 busy during run", int'(busy), 1);
    end
    check("R5 done pulse", int'(done), 1);
    check("R5 busy low at done", int'(busy), 0);
    check(poke ? "R8 result" : "R1 product", int'(prod), x * y);
    @(negedge clk);
    check("R5 done one cycle", int'(done), 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R5 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    #13;
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 product", int'(prod), 0);
    rst_n = 1'b1;
    // R6 worked example
    @(negedge clk);
    a = 4'b0010; b = 4'b0011; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); check("R6 step1", int'(prod), 8'h11);
    @(negedge clk); check("R6 step2", int'(prod), 8'h18);
    @(negedge clk); @(negedge clk);
    check("R6 result", int'(prod), 8'h06);
    check("R6 done", int'(done), 1);
    // R7 carry out kept
    run_op(15, 15, 1'b0, 1'b1);
    check("R7 max product", int'(prod), 225);
    // R1/R3/R4 exhaustive sweep
    for (int x = 0; x < (1 << NB); x++)
      for (int y = 0; y < (1 << NB); y++)
        run_op(x, y, 1'b0, 1'b1);
    // R8 start while busy
    run_op(9, 13, 1'b1, 1'b0);
    run_op(15, 1, 1'b1, 1'b0);
    // R9 hold while idle
    for (int i = 0; i < 6; i++) begin
      a = NB'(i + 3); b = NB'(7 - i);
      @(negedge clk);
      check("R9 idle hold", int'(prod), 15);
      check("R9 idle busy", int'(busy), 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule